// File: doc/BRIEF.md
# SPI Data FIFO Pair with Direction Interrupts

This block holds the data path between a register bus and a serial shift engine. A transmit queue collects words the host writes and hands them to the engine. A receive queue collects words the engine produces and hands them to the host. Each queue is 16 entries deep and reports its fill level in a status word. A configuration word sets two fill thresholds and the entry width, which is one to four bytes. Bytes above the programmed width are stored as zero.

Each direction has an event-flag register, an enable register with the same bit layout, and a write-one-to-clear port. Flags are set by transitions of the fill level and by a slave-release pulse from the engine. Each direction drives its own level interrupt line. Either queue can be flushed on its own by a strobe bit in the configuration write. A flush empties the queue in one cycle and never raises a flag. Address decode and the shift engine sit outside the block. Every register access arrives here as a strobe with write data.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both fill counts are 0, all flags and enables are 0, both interrupt lines are low, and the configuration readback shows both thresholds at 0 and width code 3.
- R2: Each queue holds up to 16 entries and returns them in the order they were written. The status word carries the receive fill count in bits 12:8 and the transmit fill count in bits 20:16. All other status bits read 0.
- R3: A host push to a full transmit queue, or an engine pop from an empty one, is ignored. An engine push to a full receive queue, or a host pop from an empty one, is ignored. In each case the fill count and the stored data do not change.
- R4: A configuration write loads the receive threshold from bits 3:0, the transmit threshold from bits 7:4 and the width code from bits 9:8, where the code is the byte count minus one. The readback shows these bits in the same positions and 0 elsewhere. Every word pushed into either queue keeps only its low (code+1) bytes; the remaining bytes are stored as zero.
- R5: A configuration write with bit 11 set empties the receive queue, and one with bit 12 set empties the transmit queue. The count is 0 in the next cycle, and a push or pop in the flush cycle is dropped. A flush sets no flag.
- R6: Transmit flag bit 0 sets when a push brings the fill level to 16. Bit 1 sets when a pop brings it to 0. Bit 5 sets when a pop moves it from above the transmit threshold to at or below it.
- R7: Receive flag bit 5 sets when a push moves the receive fill level from at or below the receive threshold to above it. Bit 6 of both flag registers sets on an engine slave-release pulse. Transmit bits 2-4 and 7, and receive bits 0-4 and 7, always read 0.
- R8: A clear write drops the flags whose data bits are 1, in the next cycle. A flag that is set in the same cycle as its clear stays set. Flags otherwise hold their value.
- R9: An enable write loads the 8-bit enable register from data bits 7:0. Each interrupt line is high exactly when some flag of its direction has its enable bit set.
- R10: A push and a pop to the same queue in one cycle both take effect when the queue is neither full nor empty, and the fill count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 32 | Write data shared by all register strobes |
| cfg_wr_i | input | 1 | Configuration write strobe; bits 11 and 12 flush the queues |
| tx_en_wr_i | input | 1 | Transmit enable register write |
| rx_en_wr_i | input | 1 | Receive enable register write |
| tx_clr_wr_i | input | 1 | Transmit flag clear write |
| rx_clr_wr_i | input | 1 | Receive flag clear write |
| cfg_o | output | 32 | Configuration readback |
| status_o | output | 32 | Fill counts of both queues |
| host_tx_push_i | input | 1 | Host writes one transmit word |
| host_tx_data_i | input | 32 | Transmit word from the host |
| host_rx_pop_i | input | 1 | Host takes the head receive word |
| host_rx_data_o | output | 32 | Head of the receive queue |
| eng_tx_pop_i | input | 1 | Engine takes the head transmit word |
| eng_tx_data_o | output | 32 | Head of the transmit queue |
| eng_tx_avail_o | output | 1 | Transmit queue not empty |
| eng_rx_push_i | input | 1 | Engine delivers one receive word |
| eng_rx_data_i | input | 32 | Receive word from the engine |
| eng_rx_space_o | output | 1 | Receive queue not full |
| eng_release_i | input | 1 | Slave-release event pulse |
| tx_flags_o | output | 8 | Transmit flag register |
| rx_flags_o | output | 8 | Receive flag register |
| tx_en_o | output | 8 | Transmit enable register |
| rx_en_o | output | 8 | Receive enable register |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
The assertions check the per-cycle invariants on every cycle. These are the count bound, the frozen pointers on a push to a full queue or a pop from an empty one, an empty queue after a flush, no new flag out of a flush, a set that wins over a clear, flags that hold when nothing acts on them, and no interrupt without a flag. Other behaviours need whole scenarios and show only in the bench. These are data order and byte masking across width changes, the threshold crossings in both directions, and the interplay of random pushes, pops, flushes, clears and enables. The bench compares them against its own queue model.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DW         = 8 * WORD_BYTES;
  localparam int unsigned FLAG_W     = 8;
  localparam int unsigned THR_W      = 4;
  localparam int unsigned CNT_FW     = 5;

  // flag bit positions
  localparam int unsigned FB_FULL  = 0;
  localparam int unsigned FB_EMPTY = 1;
  localparam int unsigned FB_THR   = 5;
  localparam int unsigned FB_REL   = 6;

  // config word fields
  localparam int unsigned CF_RX_FLUSH = 11;
  localparam int unsigned CF_TX_FLUSH = 12;

  localparam logic [FLAG_W-1:0] TX_IMPL = FLAG_W'((1 << FB_FULL) | (1 << FB_EMPTY) |
                                                  (1 << FB_THR) | (1 << FB_REL));
  localparam logic [FLAG_W-1:0] RX_IMPL = FLAG_W'((1 << FB_THR) | (1 << FB_REL));

  typedef struct packed {
    logic [1:0]       width_code;
    logic [THR_W-1:0] tx_thr;
    logic [THR_W-1:0] rx_thr;
  } cfg_t;

  function automatic logic [DW-1:0] width_mask(input logic [1:0] code);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < int'(WORD_BYTES); b++)
      if (b <= int'(code)) m[b*8 +: 8] = 8'hff;
    return m;
  endfunction
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;

  always_comb begin
    if (flush_i) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= inc_ptr(wr_ptr_q);
        if (pop_ok)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o   = mem_q[rd_ptr_q];
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> ($stable(cnt_q) && $stable(wr_ptr_q)));
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> ($stable(rd_ptr_q) && cnt_q == '0));
  p_flush_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && wr_ptr_q == rd_ptr_q));
  p_push_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags #(
  parameter int unsigned    NF   = 8,
  parameter logic [NF-1:0]  IMPL = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          clr_wr_i,
  input  logic [NF-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] en_o,
  output logic          irq_o
);
  logic [NF-1:0] flags_q, en_q, clr_mask;

  assign clr_mask = clr_wr_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= ((flags_q & ~clr_mask) | set_i) & IMPL;
      if (en_wr_i) en_q <= en_i;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & IMPL) != '0) |=> ((flags_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && (clr_i & set_i) == '0) |=> ((flags_o & $past(clr_i)) == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && !clr_wr_i) |=> $stable(flags_o));
  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == '0) |-> !irq_o);
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       wdata_i,
  input  logic              cfg_wr_i,
  input  logic              tx_en_wr_i,
  input  logic              rx_en_wr_i,
  input  logic              tx_clr_wr_i,
  input  logic              rx_clr_wr_i,
  output logic [31:0]       cfg_o,
  output logic [31:0]       status_o,
  input  logic              host_tx_push_i,
  input  logic [DW-1:0]     host_tx_data_i,
  input  logic              host_rx_pop_i,
  output logic [DW-1:0]     host_rx_data_o,
  input  logic              eng_tx_pop_i,
  output logic [DW-1:0]     eng_tx_data_o,
  output logic              eng_tx_avail_o,
  input  logic              eng_rx_push_i,
  input  logic [DW-1:0]     eng_rx_data_i,
  output logic              eng_rx_space_o,
  input  logic              eng_release_i,
  output logic [FLAG_W-1:0] tx_flags_o,
  output logic [FLAG_W-1:0] rx_flags_o,
  output logic [FLAG_W-1:0] tx_en_o,
  output logic [FLAG_W-1:0] rx_en_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  cfg_t          cfg_q;
  logic          tx_flush, rx_flush;
  logic [DW-1:0] keep_mask;
  logic [CW-1:0] tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt, tx_thr, rx_thr;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [FLAG_W-1:0] tx_set, rx_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{width_code: 2'd3, tx_thr: '0, rx_thr: '0};
    else if (cfg_wr_i) cfg_q <= cfg_t'(wdata_i[$bits(cfg_t)-1:0]);
  end

  assign tx_flush  = cfg_wr_i & wdata_i[CF_TX_FLUSH];
  assign rx_flush  = cfg_wr_i & wdata_i[CF_RX_FLUSH];
  assign keep_mask = width_mask(cfg_q.width_code);

  spi_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_tx_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (tx_flush),
    .push_i    (host_tx_push_i),
    .wdata_i   (host_tx_data_i & keep_mask),
    .pop_i     (eng_tx_pop_i),
    .rdata_o   (eng_tx_data_o),
    .cnt_o     (tx_cnt),
    .cnt_nxt_o (tx_cnt_nxt),
    .full_o    (tx_full),
    .empty_o   (tx_empty)
  );

  spi_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_rx_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (rx_flush),
    .push_i    (eng_rx_push_i),
    .wdata_i   (eng_rx_data_i & keep_mask),
    .pop_i     (host_rx_pop_i),
    .rdata_o   (host_rx_data_o),
    .cnt_o     (rx_cnt),
    .cnt_nxt_o (rx_cnt_nxt),
    .full_o    (rx_full),
    .empty_o   (rx_empty)
  );

  assign eng_tx_avail_o = ~tx_empty;
  assign eng_rx_space_o = ~rx_full;
  assign tx_thr = CW'(cfg_q.tx_thr);
  assign rx_thr = CW'(cfg_q.rx_thr);

  // flags fire on level transitions caused by push/pop, never on flush
  always_comb begin
    tx_set = '0;
    rx_set = '0;
    tx_set[FB_FULL]  = ~tx_flush & (tx_cnt_nxt == CW'(DEPTH)) & ~tx_full;
    tx_set[FB_EMPTY] = ~tx_flush & (tx_cnt_nxt == '0) & ~tx_empty;
    tx_set[FB_THR]   = ~tx_flush & (tx_cnt_nxt <= tx_thr) & (tx_cnt > tx_thr);
    tx_set[FB_REL]   = eng_release_i;
    rx_set[FB_THR]   = ~rx_flush & (rx_cnt_nxt > rx_thr) & (rx_cnt <= rx_thr);
    rx_set[FB_REL]   = eng_release_i;
  end

  spi_irq_flags #(.NF(FLAG_W), .IMPL(TX_IMPL)) u_tx_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (tx_set),
    .clr_wr_i (tx_clr_wr_i),
    .clr_i    (wdata_i[FLAG_W-1:0]),
    .en_wr_i  (tx_en_wr_i),
    .en_i     (wdata_i[FLAG_W-1:0]),
    .flags_o  (tx_flags_o),
    .en_o     (tx_en_o),
    .irq_o    (tx_irq_o)
  );

  spi_irq_flags #(.NF(FLAG_W), .IMPL(RX_IMPL)) u_rx_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (rx_set),
    .clr_wr_i (rx_clr_wr_i),
    .clr_i    (wdata_i[FLAG_W-1:0]),
    .en_wr_i  (rx_en_wr_i),
    .en_i     (wdata_i[FLAG_W-1:0]),
    .flags_o  (rx_flags_o),
    .en_o     (rx_en_o),
    .irq_o    (rx_irq_o)
  );

  always_comb begin
    cfg_o = '0;
    cfg_o[$bits(cfg_t)-1:0] = cfg_q;
    status_o = '0;
    status_o[8  +: CNT_FW] = CNT_FW'(rx_cnt);
    status_o[16 +: CNT_FW] = CNT_FW'(tx_cnt);
  end

  p_flush_quiet_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flush && !eng_release_i) |=> ((tx_flags_o & ~$past(tx_flags_o)) == '0));
  p_flush_quiet_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush && !eng_release_i) |=> ((rx_flags_o & ~$past(rx_flags_o)) == '0));
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_release_i |=> (tx_flags_o[FB_REL] && rx_flags_o[FB_REL]));
endmodule

// File: tb/spi_fifo_pair_bench.sv
`timescale 1ns/1ps
module spi_fifo_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] wd = '0, hd = '0, ed = '0;
  logic cfgw = 0, txew = 0, rxew = 0, txcw = 0, rxcw = 0;
  logic push = 0, hpop = 0, epop = 0, epush = 0, rel = 0;

  logic [31:0] cfg_o, status_o, host_rx_data, eng_tx_data;
  logic eng_tx_avail, eng_rx_space, tx_irq, rx_irq;
  logic [7:0] tx_flags, rx_flags, tx_en, rx_en;

  spi_fifo_pair u_spi_fifo_pair (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wd), .cfg_wr_i(cfgw),
    .tx_en_wr_i(txew), .rx_en_wr_i(rxew), .tx_clr_wr_i(txcw), .rx_clr_wr_i(rxcw),
    .cfg_o(cfg_o), .status_o(status_o),
    .host_tx_push_i(push), .host_tx_data_i(hd), .host_rx_pop_i(hpop),
    .host_rx_data_o(host_rx_data), .eng_tx_pop_i(epop), .eng_tx_data_o(eng_tx_data),
    .eng_tx_avail_o(eng_tx_avail), .eng_rx_push_i(epush), .eng_rx_data_i(ed),
    .eng_rx_space_o(eng_rx_space), .eng_release_i(rel),
    .tx_flags_o(tx_flags), .rx_flags_o(rx_flags), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  // reference model
  logic [31:0] txq[$], rxq[$];
  logic [7:0]  m_tf = 0, m_rf = 0, m_ten = 0, m_ren = 0;
  logic [3:0]  m_txthr = 0, m_rxthr = 0;
  logic [1:0]  m_wc = 2'd3;
  int vectors = 0, miscompares = 0;

  function automatic logic [31:0] byte_keep(input logic [1:0] c);
    case (c)
      2'd0: return 32'h0000_00ff;
      2'd1: return 32'h0000_ffff;
      2'd2: return 32'h00ff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] st;
    st = '0;
    st[12:8]  = 5'(rxq.size());
    st[20:16] = 5'(txq.size());
    chk({tag, " R2 status"}, status_o, st);
    chk({tag, " R4 cfg"}, cfg_o, {22'd0, m_wc, m_txthr, m_rxthr});
    chk({tag, " R3 tx avail"}, 32'(eng_tx_avail), 32'(txq.size() != 0));
    chk({tag, " R3 rx space"}, 32'(eng_rx_space), 32'(rxq.size() != 16));
    if (txq.size() != 0) chk({tag, " R2 tx head"}, eng_tx_data, txq[0]);
    if (rxq.size() != 0) chk({tag, " R2 rx head"}, host_rx_data, rxq[0]);
    chk({tag, " R6 tx flags"}, 32'(tx_flags), 32'(m_tf));
    chk({tag, " R7 rx flags"}, 32'(rx_flags), 32'(m_rf));
    chk({tag, " R9 tx en"}, 32'(tx_en), 32'(m_ten));
    chk({tag, " R9 rx en"}, 32'(rx_en), 32'(m_ren));
    chk({tag, " R9 tx irq"}, 32'(tx_irq), 32'(|(m_tf & m_ten)));
    chk({tag, " R9 rx irq"}, 32'(rx_irq), 32'(|(m_rf & m_ren)));
  endtask

  // model one clock with the driven inputs, then tick and check at the falling edge
  task automatic step(input string tag);
    logic [31:0] keep;
    logic [7:0] ts, rs;
    int s0, s1;
    keep = byte_keep(m_wc);
    ts = '0; rs = '0;
    s0 = txq.size();
    if (!(cfgw && wd[12])) begin
      if (epop && s0 > 0) void'(txq.pop_front());
      if (push && s0 < 16) txq.push_back(hd & keep);
      s1 = txq.size();
      if (s1 == 16 && s0 != 16) ts[0] = 1;
      if (s1 == 0 && s0 != 0) ts[1] = 1;
      if (s1 <= int'(m_txthr) && s0 > int'(m_txthr)) ts[5] = 1;
    end else txq.delete();
    s0 = rxq.size();
    if (!(cfgw && wd[11])) begin
      if (hpop && s0 > 0) void'(rxq.pop_front());
      if (epush && s0 < 16) rxq.push_back(ed & keep);
      s1 = rxq.size();
      if (s1 > int'(m_rxthr) && s0 <= int'(m_rxthr)) rs[5] = 1;
    end else rxq.delete();
    ts[6] = rel; rs[6] = rel;
    m_tf = ((m_tf & ~(txcw ? wd[7:0] : 8'h00)) | ts) & 8'h63;
    m_rf = ((m_rf & ~(rxcw ? wd[7:0] : 8'h00)) | rs) & 8'h60;
    if (txew) m_ten = wd[7:0];
    if (rxew) m_ren = wd[7:0];
    if (cfgw) begin
      m_rxthr = wd[3:0]; m_txthr = wd[7:4]; m_wc = wd[9:8];
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    check_all(tag);
    {cfgw, txew, rxew, txcw, rxcw, push, hpop, epop, epush, rel} = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    vectors++;
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R6: overfill TX, extra pushes dropped, full flag raised
    for (int i = 0; i < 20; i++) begin
      push = 1; hd = 32'h1000_0000 + 32'(i);
      step("R3 tx overfill");
    end
    // R5: flush TX, no new flag
    cfgw = 1; wd = 32'h0000_1300; step("R5 tx flush");
    // R3: host pop on empty RX
    hpop = 1; step("R3 rx underflow");
    // R4: one-byte width, engine push
    cfgw = 1; wd = 32'h0000_0022; step("R4 width 1 byte");
    epush = 1; ed = 32'hA5C3_5A3C; step("R4 masked push");
    epush = 1; ed = 32'h0102_0304; step("R7 rx above thr");
    epush = 1; ed = 32'hFFFF_FF77; step("R7 rx above thr");
    // R10: push and pop together
    epush = 1; hpop = 1; ed = 32'h55; step("R10 rx push+pop");
    // R8: clear and release in the same cycle; release wins
    rel = 1; step("R7 release");
    rxcw = 1; wd = 32'hFF; rel = 1; step("R8 set beats clear");
    rxcw = 1; wd = 32'hFF; step("R8 clear");
    // R9: enables
    rxew = 1; wd = 32'h20; step("R9 rx enable");
    epush = 1; ed = 32'h9; step("R9 rx irq");
    cfgw = 1; wd = 32'h0000_0B00; step("R5 rx flush");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      int ph, r;
      ph = (i / 500) % 4;
      push  = ($urandom % 100) < ((ph == 0) ? 70 : 35);
      epop  = ($urandom % 100) < ((ph == 1) ? 70 : 35);
      epush = ($urandom % 100) < ((ph == 2) ? 70 : 35);
      hpop  = ($urandom % 100) < ((ph == 3) ? 70 : 35);
      rel   = ($urandom % 100) < 3;
      hd = $urandom; ed = $urandom; wd = $urandom;
      r = $urandom % 100;
      if (r < 3) begin
        cfgw = 1;
        if (($urandom % 4) != 0) wd[12:11] = 2'b00;
      end
      else if (r < 6)  txew = 1;
      else if (r < 9)  rxew = 1;
      else if (r < 13) txcw = 1;
      else if (r < 17) rxcw = 1;
      step("R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule